// File: doc/BRIEF.md
# Big-Endian Sub-Word Lane Aligner

This block sits between a 32-bit memory word and the register file and shapes data for narrow memory accesses. On a narrow store it merges an 8-bit or 16-bit register value into the existing memory word. On a narrow load it picks a byte or half-word out of the memory word and zero- or sign-extends it to 32 bits. In this word layout narrow data always sits in the most significant lanes: a byte in bits 31..24 and a half-word in bits 31..16.

The same datapath also extends a value that is already in a register, from bit 7 or bit 15. It also performs two half-word immediate inserts, each of which writes one half of a register and leaves the other half as it was. The block is purely combinational. A 4-bit operation code selects the function. The `base_word` input carries the old memory word on stores, the memory word on loads, and the register value on inserts and extends. The `opnd_word` input carries the value to be stored or the immediate. Address generation and the memory itself sit outside the block.

Top module: `be_lane_aligner`

## Requirements
- R1: Code 6 (byte store) gives `{opnd_word[7:0], base_word[23:0]}`.
- R2: Code 7 (half-word store) gives `{opnd_word[15:0], base_word[15:0]}`.
- R3: Code 1 (unsigned byte load) gives `base_word[31:24]` zero-filled. Code 2 (signed byte load) gives the same byte sign-extended from its top bit, which is `base_word[31]`.
- R4: Code 3 (unsigned half-word load) gives `base_word[31:16]` zero-filled. Code 4 (signed half-word load) gives the same half-word sign-extended from `base_word[31]`.
- R5: Code 8 (low insert) gives `{base_word[31:16], opnd_word[15:0]}`.
- R6: Code 9 (high insert) gives `{opnd_word[15:0], base_word[15:0]}`.
- R7: Codes 10 and 11 sign-extend and zero-extend `base_word[7:0]` respectively. Codes 12 and 13 sign-extend and zero-extend `base_word[15:0]` respectively.
- R8: Code 0 (word load) gives `base_word` unchanged. Code 5 (word store) gives `opnd_word` unchanged.
- R9: Codes 14 and 15 are unsupported. They drive `illegal_op` high and give `base_word` unchanged. Every other code drives `illegal_op` low.
- R10: For every code from 0 to 4 and from 10 to 13, `opnd_word` has no effect on the result.
- R11: The result follows the inputs in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation select, using the encodings given in R1 to R9 |
| base_word | input | 32 | Memory word (loads and stores) or register value (inserts and extends) |
| opnd_word | input | 32 | Store data or immediate |
| result_word | output | 32 | Aligned, merged or extended result |
| illegal_op | output | 1 | High when the operation code is unsupported |

## Verification
The hardest cases to reach are the sign boundaries. A sign error shows only when the field's top bit is set while nearby lanes hold values that would reveal a wrong fill or a wrong lane. The stimulus therefore pairs base words whose upper and lower fields have opposite sign bits, and it uses operands with both upper and lower halves non-zero. Directed cases then hold the base word fixed and change the operand under the load and extend codes, which shows that the operand is ignored there. They also place exactly 0x80 and 0x7FFF at the lane edges, where a one-bit slip in the field select changes the result.

// File: rtl/be_lane_aligner.sv
module be_lane_aligner #(
  parameter int WORD_W = 32,
  parameter int OP_W   = 4
) (
  input  logic [OP_W-1:0]   op_code,
  input  logic [WORD_W-1:0] base_word,
  input  logic [WORD_W-1:0] opnd_word,
  output logic [WORD_W-1:0] result_word,
  output logic              illegal_op
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = WORD_W / 2;

  localparam logic [OP_W-1:0] OP_LD_W  = 4'd0;
  localparam logic [OP_W-1:0] OP_LD_BU = 4'd1;
  localparam logic [OP_W-1:0] OP_LD_BS = 4'd2;
  localparam logic [OP_W-1:0] OP_LD_HU = 4'd3;
  localparam logic [OP_W-1:0] OP_LD_HS = 4'd4;
  localparam logic [OP_W-1:0] OP_ST_W  = 4'd5;
  localparam logic [OP_W-1:0] OP_ST_B  = 4'd6;
  localparam logic [OP_W-1:0] OP_ST_H  = 4'd7;
  localparam logic [OP_W-1:0] OP_INS_L = 4'd8;
  localparam logic [OP_W-1:0] OP_INS_H = 4'd9;
  localparam logic [OP_W-1:0] OP_EX_BS = 4'd10;
  localparam logic [OP_W-1:0] OP_EX_BZ = 4'd11;
  localparam logic [OP_W-1:0] OP_EX_HS = 4'd12;
  localparam logic [OP_W-1:0] OP_EX_HZ = 4'd13;

  logic [BYTE_W-1:0] top_byte, low_byte, st_byte;
  logic [HALF_W-1:0] top_half, low_half, st_half;

  assign top_byte = base_word[WORD_W-1 -: BYTE_W];
  assign top_half = base_word[WORD_W-1 -: HALF_W];
  assign low_byte = base_word[BYTE_W-1:0];
  assign low_half = base_word[HALF_W-1:0];
  assign st_byte  = opnd_word[BYTE_W-1:0];
  assign st_half  = opnd_word[HALF_W-1:0];

  always_comb begin
    result_word = base_word;
    illegal_op  = 1'b0;
    case (op_code)
      OP_LD_W:  result_word = base_word;
      OP_LD_BU: result_word = {{(WORD_W-BYTE_W){1'b0}}, top_byte};
      OP_LD_BS: result_word = {{(WORD_W-BYTE_W){top_byte[BYTE_W-1]}}, top_byte};
      OP_LD_HU: result_word = {{(WORD_W-HALF_W){1'b0}}, top_half};
      OP_LD_HS: result_word = {{(WORD_W-HALF_W){top_half[HALF_W-1]}}, top_half};
      OP_ST_W:  result_word = opnd_word;
      OP_ST_B:  result_word = {st_byte, base_word[WORD_W-BYTE_W-1:0]};
      OP_ST_H:  result_word = {st_half, base_word[HALF_W-1:0]};
      OP_INS_L: result_word = {top_half, st_half};
      OP_INS_H: result_word = {st_half, low_half};
      OP_EX_BS: result_word = {{(WORD_W-BYTE_W){low_byte[BYTE_W-1]}}, low_byte};
      OP_EX_BZ: result_word = {{(WORD_W-BYTE_W){1'b0}}, low_byte};
      OP_EX_HS: result_word = {{(WORD_W-HALF_W){low_half[HALF_W-1]}}, low_half};
      OP_EX_HZ: result_word = {{(WORD_W-HALF_W){1'b0}}, low_half};
      default: begin
        result_word = base_word;
        illegal_op  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/be_lane_aligner_chk.sv
module be_lane_aligner_chk #(
  parameter int WORD_W = 32,
  parameter int OP_W   = 4
) (
  input logic [OP_W-1:0]   op_code,
  input logic [WORD_W-1:0] base_word,
  input logic [WORD_W-1:0] opnd_word,
  input logic [WORD_W-1:0] result_word,
  input logic              illegal_op
);
  always_comb begin
    if (op_code == 4'd6)
      p_byte_store_r1: assert (result_word[31:24] == opnd_word[7:0] && result_word[23:0] == base_word[23:0]);
    if (op_code == 4'd7)
      p_half_store_r2: assert (result_word[31:16] == opnd_word[15:0] && result_word[15:0] == base_word[15:0]);
    if (op_code == 4'd1 || op_code == 4'd2)
      p_byte_load_r3: assert (result_word[7:0] == base_word[31:24] &&
                              result_word[31:8] == ((op_code == 4'd2 && base_word[31]) ? 24'hFFFFFF : 24'h0));
    if (op_code == 4'd3 || op_code == 4'd4)
      p_half_load_r4: assert (result_word[15:0] == base_word[31:16] &&
                              result_word[31:16] == ((op_code == 4'd4 && base_word[31]) ? 16'hFFFF : 16'h0));
    if (op_code == 4'd8)
      p_ins_low_r5: assert (result_word[31:16] == base_word[31:16] && result_word[15:0] == opnd_word[15:0]);
    if (op_code == 4'd9)
      p_ins_high_r6: assert (result_word[31:16] == opnd_word[15:0] && result_word[15:0] == base_word[15:0]);
    if (op_code >= 4'd10 && op_code <= 4'd13)
      p_ext_low_r7: assert (op_code < 4'd12 ? result_word[7:0] == base_word[7:0] : result_word[15:0] == base_word[15:0]);
    if (op_code == 4'd0)
      p_word_load_r8: assert (result_word == base_word);
    if (op_code == 4'd5)
      p_word_store_r8: assert (result_word == opnd_word);
    p_illegal_flag_r9: assert (illegal_op == (op_code >= 4'd14));
    if (illegal_op)
      p_illegal_pass_r9: assert (result_word == base_word);
  end
endmodule

bind be_lane_aligner be_lane_aligner_chk #(.WORD_W(WORD_W), .OP_W(OP_W)) u_chk (
  .op_code(op_code), .base_word(base_word), .opnd_word(opnd_word),
  .result_word(result_word), .illegal_op(illegal_op)
);

// File: tb/sim_be_lane_aligner.sv
module sim_be_lane_aligner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  op_code;
  logic [31:0] base_word, opnd_word, result_word;
  logic        illegal_op;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  be_lane_aligner u0 (.op_code(op_code), .base_word(base_word), .opnd_word(opnd_word),
                      .result_word(result_word), .illegal_op(illegal_op));

  localparam int NV = 30;
  localparam logic [100:0] VEC [NV] = '{
    {4'd0,  32'hA5C37E81, 32'h1234F6D9, 32'hA5C37E81, 1'b0},
    {4'd1,  32'hA5C37E81, 32'h1234F6D9, 32'h000000A5, 1'b0},
    {4'd2,  32'hA5C37E81, 32'h1234F6D9, 32'hFFFFFFA5, 1'b0},
    {4'd3,  32'hA5C37E81, 32'h1234F6D9, 32'h0000A5C3, 1'b0},
    {4'd4,  32'hA5C37E81, 32'h1234F6D9, 32'hFFFFA5C3, 1'b0},
    {4'd5,  32'hA5C37E81, 32'h1234F6D9, 32'h1234F6D9, 1'b0},
    {4'd6,  32'hA5C37E81, 32'h1234F6D9, 32'hD9C37E81, 1'b0},
    {4'd7,  32'hA5C37E81, 32'h1234F6D9, 32'hF6D97E81, 1'b0},
    {4'd8,  32'hA5C37E81, 32'h1234F6D9, 32'hA5C3F6D9, 1'b0},
    {4'd9,  32'hA5C37E81, 32'h1234F6D9, 32'hF6D97E81, 1'b0},
    {4'd10, 32'hA5C37E81, 32'h1234F6D9, 32'hFFFFFF81, 1'b0},
    {4'd11, 32'hA5C37E81, 32'h1234F6D9, 32'h00000081, 1'b0},
    {4'd12, 32'hA5C37E81, 32'h1234F6D9, 32'h00007E81, 1'b0},
    {4'd13, 32'hA5C37E81, 32'h1234F6D9, 32'h00007E81, 1'b0},
    {4'd14, 32'hA5C37E81, 32'h1234F6D9, 32'hA5C37E81, 1'b1},
    {4'd15, 32'hA5C37E81, 32'h1234F6D9, 32'hA5C37E81, 1'b1},
    {4'd1,  32'h4B3CD27F, 32'hCAFE0155, 32'h0000004B, 1'b0},
    {4'd2,  32'h4B3CD27F, 32'hCAFE0155, 32'h0000004B, 1'b0},
    {4'd3,  32'h4B3CD27F, 32'hCAFE0155, 32'h00004B3C, 1'b0},
    {4'd4,  32'h4B3CD27F, 32'hCAFE0155, 32'h00004B3C, 1'b0},
    {4'd5,  32'h4B3CD27F, 32'hCAFE0155, 32'hCAFE0155, 1'b0},
    {4'd6,  32'h4B3CD27F, 32'hCAFE0155, 32'h553CD27F, 1'b0},
    {4'd7,  32'h4B3CD27F, 32'hCAFE0155, 32'h0155D27F, 1'b0},
    {4'd8,  32'h4B3CD27F, 32'hCAFE0155, 32'h4B3C0155, 1'b0},
    {4'd9,  32'h4B3CD27F, 32'hCAFE0155, 32'h0155D27F, 1'b0},
    {4'd10, 32'h4B3CD27F, 32'hCAFE0155, 32'h0000007F, 1'b0},
    {4'd11, 32'h4B3CD27F, 32'hCAFE0155, 32'h0000007F, 1'b0},
    {4'd12, 32'h4B3CD27F, 32'hCAFE0155, 32'hFFFFD27F, 1'b0},
    {4'd13, 32'h4B3CD27F, 32'hCAFE0155, 32'h0000D27F, 1'b0},
    {4'd0,  32'h4B3CD27F, 32'hCAFE0155, 32'h4B3CD27F, 1'b0}
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd6: return "R1";
      4'd7: return "R2";
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd8: return "R5";
      4'd9: return "R6";
      4'd10, 4'd11, 4'd12, 4'd13: return "R7";
      4'd0, 4'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] exp_r, input logic exp_i);
    total++;
    if (result_word !== exp_r || illegal_op !== exp_i) begin
      bad++;
      $display("FAIL %s op=%0d result=%h illegal=%b expected result=%h illegal=%b",
               req, op_code, result_word, illegal_op, exp_r, exp_i);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] b, input logic [31:0] o);
    @(negedge clk);
    op_code = op; base_word = b; opnd_word = o;
    #1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    op_code = 4'd0; base_word = '0; opnd_word = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: word load of zero, no illegal flag (R8, R9)
    drive(4'd0, 32'h0, 32'h0);
    check("R8", 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][100:97], VEC[i][96:65], VEC[i][64:33]);
      check(req_of(VEC[i][100:97]), VEC[i][32:1], VEC[i][0]);
    end

    // sign boundaries (R3, R4, R7)
    drive(4'd2, 32'h80000000, 32'h0);  check("R3", 32'hFFFFFF80, 1'b0);
    drive(4'd2, 32'h7FFFFFFF, 32'h0);  check("R3", 32'h0000007F, 1'b0);
    drive(4'd4, 32'h7FFF0000, 32'h0);  check("R4", 32'h00007FFF, 1'b0);
    drive(4'd4, 32'h8000FFFF, 32'h0);  check("R4", 32'hFFFF8000, 1'b0);
    drive(4'd10, 32'hFFFFFF7F, 32'h0); check("R7", 32'h0000007F, 1'b0);
    drive(4'd12, 32'h00008000, 32'h0); check("R7", 32'hFFFF8000, 1'b0);

    // operand ignored for loads and extends (R10)
    for (int op = 0; op < 14; op++) begin
      if (op == 5 || (op >= 6 && op <= 9)) continue;
      drive(4'(op), 32'hC0DE8A17, 32'h00000000);
      begin
        logic [31:0] first;
        first = result_word;
        drive(4'(op), 32'hC0DE8A17, 32'hFFFFFFFF);
        check("R10", first, 1'b0);
      end
    end

    // same-cycle response, no register in path (R11)
    @(negedge clk);
    op_code = 4'd9; base_word = 32'h11112222; opnd_word = 32'h0000ABCD;
    #1 check("R11", 32'hABCD2222, 1'b0);
    op_code = 4'd8;
    #1 check("R11", 32'h1111ABCD, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule